// File: doc/BRIEF.md
# Amplifier Fault Flags and Online Enable Register

This block keeps the eight-bit health word of a power amplifier and applies the host's eight-bit command byte to it. Seven one-cycle event pulses from the monitoring logic (fan failure, restart, reverse-power trip, overdrive warning, over-temperature warning, overdrive trip and over-temperature trip) each set a flag. A flag stays set until the host writes a one to the matching command bit.

The remaining bit is the online enable. Only a host command can turn it on. A host command or any of the three trip events can turn it off. The serial transport reads the health word and delivers command bytes through a single-cycle write strobe. The analog sensing upstream produces the event pulses.

Both outputs come from registers. An event or command sampled on one rising clock edge shows up on the outputs right after that edge. The asynchronous reset input is asserted at once and released through a short synchronizer.

Top module: `amp_status_ctrl`

## Requirements
- R1: The health word layout, from bit 7 down to bit 0, is: fan failure, online, restart flag, reverse-power trip, overdrive warning, over-temperature warning, overdrive trip, over-temperature trip. `amp_enable` always equals bit 6.
- R2: After reset the health word reads 0x20: the restart flag is set and every other bit, including online, is 0.
- R3: An event pulse sets its flag on the next clock edge. The event mapping is: `fault_evt[6]` sets bit 7, and `fault_evt[k]` sets bit k for k from 0 to 5.
- R4: A set flag stays set while no clear command for it arrives. A command byte with a 0 in a flag's position leaves that flag unchanged.
- R5: A command byte with a 1 in any position other than bit 6 clears that flag on the edge where the strobe is sampled.
- R6: When an event and a clear for the same flag arrive in the same cycle, the flag ends up set.
- R7: A command with bit 6 = 1 turns online on. A command with bit 6 = 0 turns it off. Nothing else can turn online on.
- R8: A trip event (`fault_evt[4]`, `fault_evt[1]` or `fault_evt[0]`) turns online off. Warning, fan and restart events (`fault_evt[2]`, `fault_evt[3]`, `fault_evt[5]`, `fault_evt[6]`) leave online unchanged.
- R9: A trip event in the same cycle as a command with bit 6 = 1 leaves online off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| fault_evt | input | 7 | One-cycle event pulses, mapped as in R3 |
| ctl_wr | input | 1 | Command byte strobe, one cycle |
| ctl_data | input | 8 | Command byte: 1 clears a flag, bit 6 sets the online state |
| status_byte | output | 8 | Registered health word |
| amp_enable | output | 1 | Online enable, equal to status bit 6 |

## Verification
The bench runs all 128 event patterns. Each pattern is applied from a clean, online state, so a swapped event-to-bit mapping or a warning that wrongly drops online shows up as a wrong health word. It clears each flag alone and checks that the other flags survive, which catches a clear that touches a neighbouring bit or a 0 command bit that clears. It also drives the two same-cycle conflicts. In one, an event meets a clear of the same flag; a design that lets the clear win would lose the fault. In the other, a trip meets an online command; a design that lets the command win would leave a faulted amplifier running.

// File: rtl/amp_stat_pkg.sv
package amp_stat_pkg;
  localparam int unsigned EVT_W     = 7;
  localparam int unsigned STAT_W    = 8;
  localparam int unsigned ONLINE_POS = 6;
  localparam int unsigned FAN_POS    = 7;
  // event-vector positions of the three trip conditions
  localparam logic [EVT_W-1:0] TRIP_EVT_MASK = 7'b001_0011;
  localparam logic [STAT_W-1:0] ONLINE_MASK  = 8'h40;
  // flag bank reset image (restart flag in status bit 5)
  localparam logic [EVT_W-1:0] FLAG_RST_VAL  = 7'b010_0000;

  // event vector -> health-word positions (online slot left at 0)
  function automatic logic [STAT_W-1:0] evt_to_word(input logic [EVT_W-1:0] e);
    return {e[EVT_W-1], 1'b0, e[EVT_W-2:0]};
  endfunction

  // health-word positions -> flag-bank order (drops online slot)
  function automatic logic [EVT_W-1:0] word_to_flags(input logic [STAT_W-1:0] w);
    return {w[FAN_POS], w[ONLINE_POS-1:0]};
  endfunction
endpackage

// File: rtl/amp_rst_sync.sv
module amp_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_q_n = chain_q[STAGES-1];
endmodule

// File: rtl/amp_sticky_bank.sv
module amp_sticky_bank #(
  parameter int unsigned      WIDTH   = 7,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] set_vec,
  input  logic [WIDTH-1:0] clr_vec,
  output logic [WIDTH-1:0] flag_q
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_flag
    logic ce;
    logic nxt;

    always_comb begin
      ce  = set_vec[i] | clr_vec[i];
      // set has priority over clear
      nxt = set_vec[i] ? 1'b1 : 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  flag_q[i] <= RST_VAL[i];
      else if (ce) flag_q[i] <= nxt;
    end
  end
endmodule

// File: rtl/amp_online_keeper.sv
module amp_online_keeper (
  input  logic clk,
  input  logic rst_n,
  input  logic cmd_wr,
  input  logic cmd_on,
  input  logic trip,
  output logic online_q
);
  logic ce;
  logic nxt;

  always_comb begin
    ce  = cmd_wr | trip;
    // a trip outranks any host command
    nxt = trip ? 1'b0 : cmd_on;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  online_q <= 1'b0;
    else if (ce) online_q <= nxt;
  end
endmodule

// File: rtl/amp_status_ctrl.sv
module amp_status_ctrl
  import amp_stat_pkg::*;
#(
  parameter int unsigned RST_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [EVT_W-1:0]  fault_evt,
  input  logic              ctl_wr,
  input  logic [STAT_W-1:0] ctl_data,
  output logic [STAT_W-1:0] status_byte,
  output logic              amp_enable
);
  logic             rst_q_n;
  logic [EVT_W-1:0] clr_vec;
  logic [EVT_W-1:0] flags;
  logic             trip;
  logic             online;

  amp_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_q_n (rst_q_n)
  );

  always_comb begin
    clr_vec = ctl_wr ? word_to_flags(ctl_data) : '0;
    trip    = |(fault_evt & TRIP_EVT_MASK);
  end

  amp_sticky_bank #(.WIDTH(EVT_W), .RST_VAL(FLAG_RST_VAL)) u_flags (
    .clk     (clk),
    .rst_n   (rst_q_n),
    .set_vec (fault_evt),
    .clr_vec (clr_vec),
    .flag_q  (flags)
  );

  amp_online_keeper u_online (
    .clk      (clk),
    .rst_n    (rst_q_n),
    .cmd_wr   (ctl_wr),
    .cmd_on   (ctl_data[ONLINE_POS]),
    .trip     (trip),
    .online_q (online)
  );

  always_comb begin
    status_byte = {flags[EVT_W-1], online, flags[EVT_W-2:0]};
    amp_enable  = online;
  end
endmodule

// File: rtl/amp_status_ctrl_chk.sv
module amp_status_ctrl_chk
  import amp_stat_pkg::*;
(
  input logic              clk,
  input logic              rst_ok,
  input logic [EVT_W-1:0]  fault_evt,
  input logic              ctl_wr,
  input logic [STAT_W-1:0] ctl_data,
  input logic [STAT_W-1:0] status_byte,
  input logic              amp_enable
);
  logic [STAT_W-1:0] evt_w;
  logic [STAT_W-1:0] clr_w;
  logic [STAT_W-1:0] keep_w;
  logic              trip_in;

  always_comb begin
    evt_w   = evt_to_word(fault_evt);
    clr_w   = ctl_wr ? (ctl_data & ~ONLINE_MASK) : '0;
    keep_w  = status_byte & ~ONLINE_MASK & ~clr_w;
    trip_in = fault_evt[4] | fault_evt[1] | fault_evt[0];
  end

  a_r3_event_sets: assert property (@(posedge clk) disable iff (!rst_ok)
    1'b1 |=> ((status_byte & $past(evt_w)) == $past(evt_w)));

  a_r4_flag_holds: assert property (@(posedge clk) disable iff (!rst_ok)
    1'b1 |=> ((status_byte & $past(keep_w)) == $past(keep_w)));

  a_r5_clear_works: assert property (@(posedge clk) disable iff (!rst_ok)
    ctl_wr |=> ((status_byte & $past(clr_w & ~evt_w)) == '0));

  a_r7_online_rise: assert property (@(posedge clk) disable iff (!rst_ok)
    $rose(amp_enable) |-> $past(ctl_wr && ctl_data[ONLINE_POS] && !trip_in));

  a_r8_trip_drops: assert property (@(posedge clk) disable iff (!rst_ok)
    trip_in |=> !amp_enable);

  a_r1_enable_bit: assert property (@(posedge clk) disable iff (!rst_ok)
    1'b1 |-> (amp_enable == status_byte[ONLINE_POS]));
endmodule

bind amp_status_ctrl amp_status_ctrl_chk u_chk (
  .clk         (clk),
  .rst_ok      (rst_q_n),
  .fault_evt   (fault_evt),
  .ctl_wr      (ctl_wr),
  .ctl_data    (ctl_data),
  .status_byte (status_byte),
  .amp_enable  (amp_enable)
);

// File: tb/sim_amp_status_ctrl.sv
`timescale 1ns/1ps
module sim_amp_status_ctrl;
  logic       clk;
  logic       rst_n;
  logic [6:0] fault_evt;
  logic       ctl_wr;
  logic [7:0] ctl_data;
  logic [7:0] status_byte;
  logic       amp_enable;

  int checks;
  int errors;
  bit done;

  amp_status_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .fault_evt(fault_evt), .ctl_wr(ctl_wr),
    .ctl_data(ctl_data), .status_byte(status_byte), .amp_enable(amp_enable)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic logic [7:0] expand(input logic [6:0] e);
    return {e[6], 1'b0, e[5:0]};
  endfunction

  function automatic logic is_trip(input logic [6:0] e);
    return e[4] | e[1] | e[0];
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  // drive one cycle of stimulus, then sample after the edge
  task automatic cyc(input logic [6:0] e, input logic wr, input logic [7:0] d);
    @(negedge clk);
    fault_evt = e; ctl_wr = wr; ctl_data = d;
    @(negedge clk);
    fault_evt = '0; ctl_wr = 1'b0; ctl_data = '0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    for (int n = 0; n < 100000; n++) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=hung expected=done");
    finish_run();
  end

  initial begin
    checks = 0; errors = 0; done = 1'b0;
    rst_n = 1'b0; fault_evt = '0; ctl_wr = 1'b0; ctl_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R2 reset image
    chk("R2 reset word", status_byte, 8'h20);
    chk("R2 reset enable", {7'b0, amp_enable}, 8'h00);

    // R5 clear restart flag, R4 idle hold
    cyc('0, 1'b1, 8'h20);
    chk("R5 clear restart", status_byte, 8'h00);

    // R3/R8/R1 sweep of every event pattern from clean online state
    for (int p = 0; p < 128; p++) begin
      logic [6:0] e;
      logic [7:0] exp;
      e = p[6:0];
      cyc('0, 1'b1, 8'hFF);
      chk("R7 online on", status_byte, 8'h40);
      cyc(e, 1'b0, '0);
      exp = expand(e) | (is_trip(e) ? 8'h00 : 8'h40);
      chk("R3 R8 event word", status_byte, exp);
      chk("R1 enable bit", {7'b0, amp_enable}, {7'b0, exp[6]});
      cyc('0, 1'b0, '0);
      chk("R4 idle hold", status_byte, exp);
    end

    // R4 zero command keeps flags, R5 single-bit clears
    cyc(7'h7F, 1'b0, '0);
    cyc('0, 1'b1, 8'h40);
    chk("R4 zero bits keep", status_byte, 8'hFF);
    for (int b = 0; b < 8; b++) begin
      logic [7:0] cur;
      if (b == 6) continue;
      cyc(7'h7F, 1'b0, '0);
      cyc('0, 1'b1, 8'h40);
      cur = 8'hFF;
      cyc('0, 1'b1, 8'h40 | (8'h01 << b));
      chk("R5 single clear", status_byte, cur & ~(8'h01 << b));
    end

    // R6 event beats clear, per flag
    for (int k = 0; k < 7; k++) begin
      logic [6:0] e;
      e = 7'h01 << k;
      cyc('0, 1'b1, 8'hBF);
      cyc(e, 1'b1, 8'hBF);
      chk("R6 event wins", status_byte & 8'hBF, expand(e));
    end

    // R9 trip against online command, each trip source
    for (int t = 0; t < 3; t++) begin
      logic [6:0] e;
      e = (t == 0) ? 7'h01 : (t == 1) ? 7'h02 : 7'h10;
      cyc('0, 1'b1, 8'hBF);
      cyc(e, 1'b1, 8'h40);
      chk("R9 trip beats online", status_byte, expand(e));
    end

    // R7 host turns off, flags untouched
    cyc('0, 1'b1, 8'hFF);
    cyc(7'h04, 1'b0, '0);
    chk("R8 warning keeps online", status_byte, 8'h44);
    cyc('0, 1'b1, 8'h00);
    chk("R7 host off", status_byte, 8'h04);
    cyc('0, 1'b0, 8'h40);
    chk("R7 no strobe no online", status_byte, 8'h04);

    // R2 second reset mid-run
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R2 async reset", status_byte, 8'h20);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R2 after release", status_byte, 8'h20);

    finish_run();
  end
endmodule